// File: doc/BRIEF.md
# Multi-Counter Windowed Watchdog

This block supervises software with three counters that advance on a shared low-speed tick. Two 16-bit supervising counters each carry three compare limits (lower window edge, warning point and upper limit). Software must service a supervising counter inside its window. Servicing too early, or letting the count run past its upper limit, raises a sticky violation. That violation drives either a reset request or a fault request, chosen per counter. Passing the warning point sets a sticky warning interrupt.

A third counter, 32 bits wide, is free-running and only raises a periodic interrupt, each time a software-chosen bit of the count toggles. A small word-addressed register port holds the enables, the limits, the action choice, the service strobes and the status flags. Two control bits decide whether counting goes on while the low-power input or the debug-halt input is high.

Top module: `mcwdt_top`

## Requirements
- R1: After reset every output is 0, all three counts read 0 and every status bit reads 0.
- R2: An enabled supervising counter adds one per tick. A disabled one holds 0 and ignores service writes. Enables are control-register (address 0) bits 0 and 1.
- R3: A service write (address 5, bit i for counter i) with count >= lower limit clears the count to 0 and raises no request.
- R4: A service write with count < lower limit leaves the count unchanged and sets that counter's violation flag.
- R5: A tick arriving while the count equals the upper limit sets the violation flag and restarts the count at 0.
- R6: The warning flag (status bits 0 and 1) sets the cycle after the count equals the warning limit. It stays set until a 1 is written to that status bit (address 6).
- R7: Control bits 3 and 4 choose the action for counters 0 and 1: 0 drives rst_req, 1 drives fault_req.
- R8: If an enabled counter's limits break lower < warning < upper, its configuration-error bit (status bits 4 and 5) reads 1, its count holds 0 and it raises no request.
- R9: While lp_state is high, all counters freeze unless control bit 8 is 1.
- R10: While dbg_halt is high, all counters freeze unless control bit 9 is 1.
- R11: The 32-bit counter (enable bit 2, bit select in control bits 20:16) sets per_irq (status bit 2) when the selected count bit toggles. It keeps counting and never drives rst_req or fault_req.
- R12: Violation flags (status bits 8 and 9) are sticky until a 1 is written to them. Limits sit at address 1+2i (lower in bits 15:0, warning in bits 31:16) and 2+2i (upper in bits 15:0). Counts read at addresses 7, 8 and 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Low-speed count enable pulse |
| lp_state | input | 1 | Low-power state indication |
| dbg_halt | input | 1 | Debugger halt indication |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| rst_req | output | 1 | Reset request |
| fault_req | output | 1 | Fault request |
| warn_irq | output | 2 | Warning interrupts, one per supervising counter |
| per_irq | output | 1 | Periodic interrupt |

## Verification
The assertions check on every cycle that counting steps by one, that a valid service clears the count, that an early service or an overrun latches a violation, that a configuration error holds the count at 0, and that frozen counters stay stable. Only the bench scenarios show whole sequences: servicing at several window positions, sticky flags surviving until the write-one-to-clear, the choice between reset and fault, and the periodic interrupt's rate for a chosen bit.

// File: rtl/mcwdt_pkg.sv
package mcwdt_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_LIM_BASE = 4'd1;
  localparam logic [ADDR_W-1:0] A_KICK = 4'd5;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd6;
  localparam logic [ADDR_W-1:0] A_CNT_BASE = 4'd7;

  localparam int B_EN = 0;
  localparam int B_PER_EN = 2;
  localparam int B_ACT = 3;
  localparam int B_RUN_LP = 8;
  localparam int B_RUN_DBG = 9;
  localparam int B_SEL = 16;
  localparam int SEL_W = 5;

  localparam int S_WARN = 0;
  localparam int S_PER = 2;
  localparam int S_CFG = 4;
  localparam int S_VIOL = 8;
endpackage

// File: rtl/mcwdt_sup_cnt.sv
module mcwdt_sup_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          adv,
  input  logic          kick,
  input  logic          warn_clr,
  input  logic          viol_clr,
  input  logic [CW-1:0] lim_lo,
  input  logic [CW-1:0] lim_warn,
  input  logic [CW-1:0] lim_hi,
  output logic [CW-1:0] cnt,
  output logic          cfg_err,
  output logic          warn_flag,
  output logic          viol_flag
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic warn_q, warn_d, viol_q, viol_d;
  logic ok, early, good, expire;

  always_comb begin
    cfg_err = en && !((lim_lo < lim_warn) && (lim_warn < lim_hi));
    ok      = en && !cfg_err;
    early   = ok && kick && (cnt_q < lim_lo);
    good    = ok && kick && !early;
    expire  = ok && adv && !kick && (cnt_q == lim_hi);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!ok)            cnt_d = '0;
    else if (good)      cnt_d = '0;
    else if (early)     cnt_d = cnt_q;
    else if (adv)       cnt_d = (cnt_q == lim_hi) ? '0 : cnt_q + 1'b1;
    warn_d = (warn_q && !warn_clr) || (ok && (cnt_q == lim_warn));
    viol_d = (viol_q && !viol_clr) || early || expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      warn_q <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      warn_q <= warn_d;
      viol_q <= viol_d;
    end
  end

  assign cnt       = cnt_q;
  assign warn_flag = warn_q;
  assign viol_flag = viol_q;

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && adv && !kick && (cnt_q != lim_hi)) |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r3_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && kick && (cnt_q >= lim_lo)) |=> (cnt_q == '0));
  a_r4_early_kick: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && kick && (cnt_q < lim_lo)) |=> (viol_q && $stable(cnt_q)));
  a_r5_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && adv && !kick && (cnt_q == lim_hi)) |=> (viol_q && cnt_q == '0));
  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ok) |=> (cnt_q == '0));
  a_r12_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_q && !viol_clr) |=> viol_q);
  a_r6_warn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_q && !warn_clr) |=> warn_q);
endmodule

// File: rtl/mcwdt_per_cnt.sv
module mcwdt_per_cnt #(
  parameter int PW = 32,
  parameter int SW = $clog2(PW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          adv,
  input  logic [SW-1:0] sel,
  input  logic          irq_clr,
  output logic [PW-1:0] cnt,
  output logic          irq
);
  logic [PW-1:0] cnt_q, cnt_d;
  logic irq_q, irq_d, toggled;

  always_comb begin
    cnt_d   = cnt_q;
    if (en && adv) cnt_d = cnt_q + 1'b1;
    toggled = (cnt_d[sel] != cnt_q[sel]);
    irq_d   = (irq_q && !irq_clr) || toggled;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  assign cnt = cnt_q;
  assign irq = irq_q;

  a_r11_per_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && adv) |=> $stable(cnt_q));
  a_r11_per_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_clr) |=> irq_q);
endmodule

// File: rtl/mcwdt_top.sv
module mcwdt_top
  import mcwdt_pkg::*;
#(
  parameter int CW      = 16,
  parameter int PW      = 32,
  parameter int NUM_SUP = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                lp_state,
  input  logic                dbg_halt,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                rst_req,
  output logic                fault_req,
  output logic [NUM_SUP-1:0]  warn_irq,
  output logic                per_irq
);
  localparam int SW = $clog2(PW);

  logic [NUM_SUP-1:0] en_q, en_d, act_q, act_d;
  logic per_en_q, per_en_d, run_lp_q, run_lp_d, run_dbg_q, run_dbg_d;
  logic [SW-1:0] sel_q, sel_d;
  logic [CW-1:0] lo_q [NUM_SUP], lo_d [NUM_SUP];
  logic [CW-1:0] wr_q [NUM_SUP], wr_d [NUM_SUP];
  logic [CW-1:0] hi_q [NUM_SUP], hi_d [NUM_SUP];

  logic [CW-1:0] cnt [NUM_SUP];
  logic [NUM_SUP-1:0] cfg_err, warn_f, viol_f, kick, warn_clr, viol_clr;
  logic [PW-1:0] per_cnt;
  logic per_f, per_clr, run, adv;
  logic wr_ctrl, wr_kick, wr_stat;

  always_comb begin
    run = !(lp_state && !run_lp_q) && !(dbg_halt && !run_dbg_q);
    adv = tick && run;
    wr_ctrl = reg_we && (reg_addr == A_CTRL);
    wr_kick = reg_we && (reg_addr == A_KICK);
    wr_stat = reg_we && (reg_addr == A_STAT);
    per_clr = wr_stat && reg_wdata[S_PER];
  end

  always_comb begin
    en_d      = en_q;
    act_d     = act_q;
    per_en_d  = per_en_q;
    run_lp_d  = run_lp_q;
    run_dbg_d = run_dbg_q;
    sel_d     = sel_q;
    if (wr_ctrl) begin
      en_d      = reg_wdata[B_EN +: NUM_SUP];
      act_d     = reg_wdata[B_ACT +: NUM_SUP];
      per_en_d  = reg_wdata[B_PER_EN];
      run_lp_d  = reg_wdata[B_RUN_LP];
      run_dbg_d = reg_wdata[B_RUN_DBG];
      sel_d     = reg_wdata[B_SEL +: SW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      act_q     <= '0;
      per_en_q  <= 1'b0;
      run_lp_q  <= 1'b0;
      run_dbg_q <= 1'b0;
      sel_q     <= '0;
    end else begin
      en_q      <= en_d;
      act_q     <= act_d;
      per_en_q  <= per_en_d;
      run_lp_q  <= run_lp_d;
      run_dbg_q <= run_dbg_d;
      sel_q     <= sel_d;
    end
  end

  for (genvar i = 0; i < NUM_SUP; i++) begin : g_sup
    localparam logic [ADDR_W-1:0] A_LA = A_LIM_BASE + ADDR_W'(2*i);
    localparam logic [ADDR_W-1:0] A_LB = A_LIM_BASE + ADDR_W'(2*i + 1);

    always_comb begin
      lo_d[i] = lo_q[i];
      wr_d[i] = wr_q[i];
      hi_d[i] = hi_q[i];
      if (reg_we && reg_addr == A_LA) begin
        lo_d[i] = reg_wdata[CW-1:0];
        wr_d[i] = reg_wdata[16 +: CW];
      end
      if (reg_we && reg_addr == A_LB) hi_d[i] = reg_wdata[CW-1:0];
      kick[i]     = wr_kick && reg_wdata[i];
      warn_clr[i] = wr_stat && reg_wdata[S_WARN + i];
      viol_clr[i] = wr_stat && reg_wdata[S_VIOL + i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[i] <= '0;
        wr_q[i] <= '0;
        hi_q[i] <= '0;
      end else begin
        lo_q[i] <= lo_d[i];
        wr_q[i] <= wr_d[i];
        hi_q[i] <= hi_d[i];
      end
    end

    mcwdt_sup_cnt #(.CW(CW)) u_sup (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en_q[i]),
      .adv       (adv),
      .kick      (kick[i]),
      .warn_clr  (warn_clr[i]),
      .viol_clr  (viol_clr[i]),
      .lim_lo    (lo_q[i]),
      .lim_warn  (wr_q[i]),
      .lim_hi    (hi_q[i]),
      .cnt       (cnt[i]),
      .cfg_err   (cfg_err[i]),
      .warn_flag (warn_f[i]),
      .viol_flag (viol_f[i])
    );

    a_r9_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !kick[i] && en_q[i] && !wr_ctrl && !reg_we) |=> $stable(cnt[i]));
  end

  mcwdt_per_cnt #(.PW(PW), .SW(SW)) u_per (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (per_en_q),
    .adv     (adv),
    .sel     (sel_q),
    .irq_clr (per_clr),
    .cnt     (per_cnt),
    .irq     (per_f)
  );

  always_comb begin
    rst_req   = |(viol_f & ~act_q);
    fault_req = |(viol_f & act_q);
    warn_irq  = warn_f;
    per_irq   = per_f;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL) begin
      reg_rdata[B_EN +: NUM_SUP]  = en_q;
      reg_rdata[B_ACT +: NUM_SUP] = act_q;
      reg_rdata[B_PER_EN]         = per_en_q;
      reg_rdata[B_RUN_LP]         = run_lp_q;
      reg_rdata[B_RUN_DBG]        = run_dbg_q;
      reg_rdata[B_SEL +: SW]      = sel_q;
    end else if (reg_addr == A_STAT) begin
      reg_rdata[S_WARN +: NUM_SUP] = warn_f;
      reg_rdata[S_PER]             = per_f;
      reg_rdata[S_CFG +: NUM_SUP]  = cfg_err;
      reg_rdata[S_VIOL +: NUM_SUP] = viol_f;
    end else if (reg_addr == A_CNT_BASE + ADDR_W'(NUM_SUP)) begin
      reg_rdata = DATA_W'(per_cnt);
    end else begin
      for (int i = 0; i < NUM_SUP; i++) begin
        if (reg_addr == A_LIM_BASE + ADDR_W'(2*i))
          reg_rdata = {DATA_W'(wr_q[i]) << 16} | DATA_W'(lo_q[i]);
        if (reg_addr == A_LIM_BASE + ADDR_W'(2*i + 1))
          reg_rdata = DATA_W'(hi_q[i]);
        if (reg_addr == A_CNT_BASE + ADDR_W'(i))
          reg_rdata = DATA_W'(cnt[i]);
      end
    end
  end

  a_r7_req_source: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_f == '0) |-> (!rst_req && !fault_req));
endmodule

// File: tb/tb_mcwdt_top.sv
module tb_mcwdt_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, lp_state = 1'b0, dbg_halt = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic rst_req, fault_req, per_irq;
  logic [1:0] warn_irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mcwdt_top dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .lp_state(lp_state),
    .dbg_halt(dbg_halt), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rst_req(rst_req),
    .fault_req(fault_req), .warn_irq(warn_irq), .per_irq(per_irq)
  );

  // {lower, warning, upper, ticks before service, expect violation}
  localparam logic [63:0] VEC [6] = '{
    {16'd4,  16'd8,  16'd12, 8'd2,  8'd1},
    {16'd4,  16'd8,  16'd12, 8'd4,  8'd0},
    {16'd4,  16'd8,  16'd12, 8'd10, 8'd0},
    {16'd0,  16'd1,  16'd2,  8'd0,  8'd0},
    {16'd10, 16'd20, 16'd30, 8'd9,  8'd1},
    {16'd10, 16'd20, 16'd30, 8'd25, 8'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic report;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      report();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 outputs", {28'd0, rst_req, fault_req, per_irq, |warn_irq}, 32'd0);
    rd(4'd6, d); chk("R1 status", d, 32'd0);
    rd(4'd7, d); chk("R1 cnt0", d, 32'd0);
    rd(4'd9, d); chk("R1 cnt2", d, 32'd0);

    // Table: counter 0, reset action; R3 R4 R6
    for (int v = 0; v < 6; v++) begin
      logic [15:0] lo, wn, hi; logic [7:0] n; logic ev;
      {lo, wn, hi, n} = VEC[v][63:8];
      ev = VEC[v][0];
      wr(4'd0, 32'd0);
      wr(4'd6, 32'h0000_0303);
      wr(4'd1, {wn, lo});
      wr(4'd2, {16'd0, hi});
      wr(4'd0, 32'd1);
      ticks(n);
      rd(4'd7, d); chk("R2 count", d, {24'd0, n});
      wr(4'd5, 32'd1);
      rd(4'd7, d); chk(ev ? "R4 early count" : "R3 kick clears", d, ev ? {24'd0, n} : 32'd0);
      chk(ev ? "R4 rst_req" : "R3 no request", {31'd0, rst_req}, {31'd0, ev});
      chk("R6 warn", {31'd0, warn_irq[0]}, {31'd0, (n >= wn)});
    end

    // R12 stickiness and W1C
    wr(4'd0, 32'd0); wr(4'd6, 32'h303);
    wr(4'd1, {16'd8, 16'd4}); wr(4'd2, 32'd12); wr(4'd0, 32'd1);
    wr(4'd5, 32'd1);
    ticks(3);
    chk("R12 sticky", {31'd0, rst_req}, 32'd1);
    wr(4'd6, 32'h100);
    chk("R12 cleared", {31'd0, rst_req}, 32'd0);

    // R6 warn W1C
    ticks(9);
    chk("R6 warn set", {30'd0, warn_irq}, 32'd1);
    wr(4'd6, 32'h1);
    chk("R6 warn cleared", {30'd0, warn_irq}, 32'd0);

    // R5 expiry, R7 fault action on counter 1
    wr(4'd0, 32'd0); wr(4'd6, 32'h303);
    wr(4'd3, {16'd2, 16'd1}); wr(4'd4, 32'd3);
    wr(4'd0, 32'h0000_0012);
    ticks(3);
    chk("R5 before expiry", {30'd0, rst_req, fault_req}, 32'd0);
    rd(4'd8, d); chk("R5 count at upper", d, 32'd3);
    ticks(1);
    chk("R7 fault_req", {30'd0, rst_req, fault_req}, 32'd1);
    rd(4'd8, d); chk("R5 count restarts", d, 32'd0);
    rd(4'd6, d); chk("R12 viol1 bit", d[9:8], 2'b10);

    // R2 disabled ignores service
    wr(4'd0, 32'd0); wr(4'd6, 32'h303);
    wr(4'd3, {16'd8, 16'd4}); wr(4'd4, 32'd12);
    wr(4'd5, 32'd2);
    ticks(2);
    rd(4'd8, d); chk("R2 disabled count", d, 32'd0);
    chk("R2 disabled no req", {30'd0, rst_req, fault_req}, 32'd0);

    // R8 configuration error
    wr(4'd1, {16'd5, 16'd5}); wr(4'd2, 32'd9);
    wr(4'd0, 32'd1);
    rd(4'd6, d); chk("R8 cfg bit", d[5:4], 2'b01);
    ticks(12);
    wr(4'd5, 32'd1);
    rd(4'd7, d); chk("R8 held", d, 32'd0);
    chk("R8 no req", {30'd0, rst_req, fault_req}, 32'd0);

    // R9 low-power freeze
    wr(4'd1, {16'd100, 16'd50}); wr(4'd2, 32'd200);
    wr(4'd0, 32'd1);
    @(negedge clk); lp_state = 1'b1;
    ticks(5);
    rd(4'd7, d); chk("R9 frozen", d, 32'd0);
    wr(4'd0, 32'h101);
    ticks(5);
    rd(4'd7, d); chk("R9 runs", d, 32'd5);
    @(negedge clk); lp_state = 1'b0;

    // R10 debug freeze
    wr(4'd0, 32'd1);
    @(negedge clk); dbg_halt = 1'b1;
    ticks(4);
    rd(4'd7, d); chk("R10 frozen", d, 32'd5);
    wr(4'd0, 32'h201);
    ticks(4);
    rd(4'd7, d); chk("R10 runs", d, 32'd9);
    @(negedge clk); dbg_halt = 1'b0;

    // R11 periodic counter, bit 2
    wr(4'd0, 32'd0); wr(4'd6, 32'h307);
    wr(4'd0, 32'h0002_0004);
    ticks(3);
    chk("R11 no irq yet", {31'd0, per_irq}, 32'd0);
    ticks(1);
    chk("R11 irq at toggle", {31'd0, per_irq}, 32'd1);
    chk("R11 no req", {30'd0, rst_req, fault_req}, 32'd0);
    wr(4'd6, 32'h4);
    ticks(3);
    chk("R11 cleared", {31'd0, per_irq}, 32'd0);
    ticks(1);
    chk("R11 again", {31'd0, per_irq}, 32'd1);
    rd(4'd9, d); chk("R11 free-running", d, 32'd8);

    done = 1;
    report();
  end
endmodule